// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps, for each of a set of branch slots picked by address, a shift register of that branch's most recent resolved outcomes. When a branch is looked up, its outcome history is used as the address into a single pattern table. Each entry of that table is a small state machine whose top bit is the taken/not-taken guess.

The fetch side drives a branch address on the lookup port and reads the prediction in the same cycle. The execute side reports each resolved branch on the training port: the address and the real outcome. On the next clock edge the outcome is shifted into that branch's history, and the pattern entry selected by the history as it stood before the shift is trained. The pattern table is common to all branches, so branches that go through the same outcome sequence train and read the same entry. A parameter selects the entry type: a 2-bit saturating counter with hysteresis, or a 1-bit last-outcome bit.

Top module: `two_level_bp`

## Requirements
- R1: After reset every history is zero, every 2-bit entry holds 01 (weakly not-taken) and every 1-bit entry holds 0, so every lookup predicts not-taken.
- R2: The history slot is selected by address bits [OFFSET_W+7:OFFSET_W] (bits [9:2] by default, 256 slots). There are no tags: addresses that differ only outside those bits share one history.
- R3: On a training update the resolved outcome enters the slot's history at bit 0, older bits move up by one and the oldest bit is dropped.
- R4: The pattern entry trained is the one indexed by the slot's history before the shift. A lookup reads the pattern entry indexed by the current history of the looked-up slot.
- R5: With CTR_W=2 an entry is a counter saturating at 0 and 3. It counts up on taken and down on not-taken, and its bit 1 is the prediction. One opposite outcome from a strong state does not flip the prediction.
- R6: With CTR_W=1 an entry stores the last outcome that trained it, and that bit is the prediction.
- R7: One pattern table serves all slots. A branch that has never been trained predicts from whatever its all-zero history entry has learned from other branches.
- R8: The prediction is combinational from the current state. A training update changes state only at the next rising clock edge, and no state changes while upd_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | ADDR_W | Branch address to predict |
| pred_taken_o | output | 1 | Prediction: 1 = taken |
| upd_valid_i | input | 1 | Training update present |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome: 1 = taken |

## Verification
The assertions check on every cycle after each update that the trained slot's history took the outcome at bit 0 with its other bits moved up. They also check that a 2-bit entry moved at most one step in the direction of the outcome without wrapping, and that a 1-bit entry equals the outcome. The sharing of the pattern table, the aliasing of untagged slots, the same-cycle visibility of a lookup and the absence of change with upd_valid_i low need whole sequences of lookups and updates. Only the bench's directed scenarios and its model-checked random traffic can show those.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int unsigned BP_MAX_HIST = 12;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR2_WEAK_NT = 2'b01;

  function automatic ctr2_t ctr2_train(ctr2_t c, logic taken);
    ctr2_t n;
    n = c;
    if (taken && c != 2'b11) n = c + 2'b01;
    else if (!taken && c != 2'b00) n = c - 2'b01;
    return n;
  endfunction

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFSET_W = 2,
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned HIST_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_pc_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  output logic [HIST_W-1:0] upd_hist_o
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  typedef logic [HIST_W-1:0] hist_t;
  typedef logic [IDX_W-1:0]  idx_t;

  hist_t hist_q [DEPTH];
  idx_t  rd_idx, upd_idx;
  hist_t upd_next;

  assign rd_idx     = rd_pc_i[OFFSET_W +: IDX_W];
  assign upd_idx    = upd_pc_i[OFFSET_W +: IDX_W];
  assign rd_hist_o  = hist_q[rd_idx];
  assign upd_hist_o = hist_q[upd_idx];
  assign upd_next   = hist_t'({upd_hist_o, upd_taken_i});

  for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      hist_q[g] <= '0;
      else if (upd_valid_i && upd_idx == idx_t'(g))     hist_q[g] <= upd_next;
    end
  end

  // Checker state: the last update as seen before the edge
  logic  chk_vld_q;
  idx_t  chk_idx_q;
  hist_t chk_old_q;
  logic  chk_dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_q <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= '0;
      chk_dir_q <= 1'b0;
    end else begin
      chk_vld_q <= upd_valid_i;
      chk_idx_q <= upd_idx;
      chk_old_q <= upd_hist_o;
      chk_dir_q <= upd_taken_i;
    end
  end

  // R3
  hist_lsb_takes_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_vld_q |-> hist_q[chk_idx_q][0] == chk_dir_q);

  if (HIST_W > 1) begin : gen_shift_chk
    // R3
    hist_shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_vld_q |-> hist_q[chk_idx_q][HIST_W-1:1] == chk_old_q[HIST_W-2:0]);
  end

endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table
  import bp_pkg::*;
#(
  parameter int unsigned HIST_W = 8,
  parameter int unsigned CTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_idx_i,
  output logic              rd_taken_o,
  input  logic              trn_valid_i,
  input  logic [HIST_W-1:0] trn_idx_i,
  input  logic              trn_taken_i
);

  localparam int unsigned DEPTH = 1 << HIST_W;

  typedef logic [CTR_W-1:0] ctr_t;

  ctr_t ctr_q [DEPTH];

  assign rd_taken_o = ctr_q[rd_idx_i][CTR_W-1];

  logic              chk_vld_q;
  logic [HIST_W-1:0] chk_idx_q;
  ctr_t              chk_old_q;
  logic              chk_dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_q <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= '0;
      chk_dir_q <= 1'b0;
    end else begin
      chk_vld_q <= trn_valid_i;
      chk_idx_q <= trn_idx_i;
      chk_old_q <= ctr_q[trn_idx_i];
      chk_dir_q <= trn_taken_i;
    end
  end

  if (CTR_W == 2) begin : gen_sat2
    for (genvar g = 0; g < DEPTH; g++) begin : gen_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          ctr_q[g] <= CTR2_WEAK_NT;
        else if (trn_valid_i && trn_idx_i == HIST_W'(g))
          ctr_q[g] <= ctr2_train(ctr_q[g], trn_taken_i);
      end
    end

    // R5
    ctr_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_vld_q |-> (chk_dir_q ? (ctr_q[chk_idx_q] >= chk_old_q)
                               : (ctr_q[chk_idx_q] <= chk_old_q)));
    // R5
    ctr_single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_vld_q |-> (ctr_q[chk_idx_q] == chk_old_q ||
                     ctr_q[chk_idx_q] == chk_old_q + 2'b01 ||
                     ctr_q[chk_idx_q] == chk_old_q - 2'b01));
  end else begin : gen_last1
    for (genvar g = 0; g < DEPTH; g++) begin : gen_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          ctr_q[g] <= '0;
        else if (trn_valid_i && trn_idx_i == HIST_W'(g))
          ctr_q[g] <= ctr_t'(trn_taken_i);
      end
    end

    // R6
    last_outcome_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_vld_q |-> ctr_q[chk_idx_q][0] == chk_dir_q);
  end

endmodule

// File: rtl/two_level_bp.sv
module two_level_bp #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFFSET_W  = 2,
  parameter int unsigned BHT_DEPTH = 256,
  parameter int unsigned HIST_W    = 8,
  parameter int unsigned CTR_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pred_pc_i,
  output logic              pred_taken_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i
);

  logic [HIST_W-1:0] rd_hist, upd_hist;

  bp_hist_table #(
    .ADDR_W  (ADDR_W),
    .OFFSET_W(OFFSET_W),
    .DEPTH   (BHT_DEPTH),
    .HIST_W  (HIST_W)
  ) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_pc_i    (pred_pc_i),
    .rd_hist_o  (rd_hist),
    .upd_valid_i(upd_valid_i),
    .upd_pc_i   (upd_pc_i),
    .upd_taken_i(upd_taken_i),
    .upd_hist_o (upd_hist)
  );

  bp_pattern_table #(
    .HIST_W(HIST_W),
    .CTR_W (CTR_W)
  ) u_pat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_hist),
    .rd_taken_o (pred_taken_o),
    .trn_valid_i(upd_valid_i),
    .trn_idx_i  (upd_hist),
    .trn_taken_i(upd_taken_i)
  );

endmodule

// File: tb/two_level_bp_bench.sv
module two_level_bp_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred_a, pred_b;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  // A: 8-bit history, 2-bit counters. B: 4-bit history, 1-bit entries.
  two_level_bp #(.HIST_W(8), .CTR_W(2)) u_two_level_bp (
    .clk_i(clk), .rst_ni(rst_ni), .pred_pc_i(pred_pc), .pred_taken_o(pred_a),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  two_level_bp #(.HIST_W(4), .CTR_W(1)) u_two_level_bp_last (
    .clk_i(clk), .rst_ni(rst_ni), .pred_pc_i(pred_pc), .pred_taken_o(pred_b),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  logic [7:0] m_hist_a [256];
  logic [3:0] m_hist_b [256];
  logic [1:0] m_ctr_a  [256];
  logic       m_ctr_b  [16];

  function automatic logic [7:0] slot(logic [31:0] pc);
    return pc[9:2];
  endfunction

  function automatic logic exp_a(logic [31:0] pc);
    return m_ctr_a[m_hist_a[slot(pc)]][1];
  endfunction

  function automatic logic exp_b(logic [31:0] pc);
    return m_ctr_b[m_hist_b[slot(pc)]];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_hist_a[i] = '0; m_hist_b[i] = '0; m_ctr_a[i] = 2'b01;
    end
    for (int i = 0; i < 16; i++) m_ctr_b[i] = 1'b0;
  endtask

  task automatic model_update(logic [31:0] pc, logic t);
    logic [7:0] ha;
    logic [3:0] hb;
    ha = m_hist_a[slot(pc)];
    hb = m_hist_b[slot(pc)];
    if (t && m_ctr_a[ha] != 2'b11) m_ctr_a[ha] = m_ctr_a[ha] + 2'b01;
    else if (!t && m_ctr_a[ha] != 2'b00) m_ctr_a[ha] = m_ctr_a[ha] - 2'b01;
    m_ctr_b[hb] = t;
    m_hist_a[slot(pc)] = {ha[6:0], t};
    m_hist_b[slot(pc)] = {hb[2:0], t};
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] ppc, logic uv, logic [31:0] upc, logic ut);
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    if (upd_valid) model_update(upd_pc, upd_taken);
  endtask

  task automatic look(logic [31:0] ppc, logic ea, logic eb, string req);
    apply(ppc, 1'b0, 32'h0, 1'b0);
    chk({req, " dut_a"}, pred_a, ea);
    chk({req, " dut_b"}, pred_b, eb);
    commit();
  endtask

  task automatic train(logic [31:0] upc, logic ut);
    apply(32'h0, 1'b1, upc, ut);
    commit();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; upd_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pool [16];
    do_reset();

    // R1: every lookup not-taken after reset
    look(32'h0000_0000, 1'b0, 1'b0, "R1");
    look(32'h0000_0040, 1'b0, 1'b0, "R1");
    look(32'h0000_03FC, 1'b0, 1'b0, "R1");

    // R8: same-cycle lookup sees the state before the update
    apply(32'h20, 1'b1, 32'h10, 1'b1);
    chk("R8 same-cycle dut_a", pred_a, 1'b0);
    chk("R8 same-cycle dut_b", pred_b, 1'b0);
    commit();
    // R7: untouched slot 0x20 (history 0) reads entry 0 trained by 0x10
    look(32'h20, 1'b1, 1'b1, "R7");
    // R3 R4: 0x10 now has history 1, entry 1 untouched
    look(32'h10, 1'b0, 1'b0, "R3 R4");

    // R5 R6: entry 0 down twice, up once
    train(32'h24, 1'b0);
    train(32'h28, 1'b0);
    train(32'h2C, 1'b1);
    look(32'h20, 1'b0, 1'b1, "R5 R6 hysteresis");

    // R8: not-taken update with upd_valid low must not touch entry 0
    apply(32'h20, 1'b0, 32'h30, 1'b0);
    commit();
    look(32'h20, 1'b0, 1'b1, "R8 ignored");
    look(32'h30, 1'b0, 1'b1, "R8 ignored");

    // R2: 0x410 aliases slot of 0x10 (history 1), trains entry 1
    train(32'h410, 1'b1);
    look(32'h2C, 1'b1, 1'b1, "R2 R4 shared entry 1");
    // 0x10 history now 3 (entry 3 untrained); without aliasing it would predict taken
    look(32'h13, 1'b0, 1'b0, "R2 alias");

    // R5: saturation
    do_reset();
    train(32'h100, 1'b1);
    train(32'h104, 1'b1);
    train(32'h108, 1'b1);
    train(32'h10C, 1'b0);
    look(32'h200, 1'b1, 1'b0, "R5 R6 saturate");

    // Random traffic against the model
    do_reset();
    for (int i = 0; i < 16; i++)
      pool[i] = {$urandom(32'd7331) & 32'h0000_0C00 | (32'(i % 6) << 2)} | ($urandom & 32'h3);
    for (int i = 0; i < 16; i++)
      pool[i] = ($urandom & 32'h0000_0C03) | (32'(i % 6) << 2);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ppc, upc;
      logic        uv, ut;
      ppc = pool[$urandom % 16];
      upc = pool[$urandom % 16];
      uv  = ($urandom % 4) != 0;
      ut  = ($urandom % 3) != 0;
      apply(ppc, uv, upc, ut);
      chk("R2,R3,R4,R5,R7 random dut_a", pred_a, exp_a(ppc));
      chk("R2,R3,R4,R6,R8 random dut_b", pred_b, exp_b(ppc));
      commit();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule